// File: doc/BRIEF.md
# Dual Phase-Frequency Comparator with Hysteretic Lock Flag

This block holds two independent phase-frequency comparators, one for an intermediate-frequency loop (channel 0) and one for a radio-frequency loop (channel 1). Each channel takes a reference pulse train and a divided-feedback pulse train. Both are synchronous to the oscillator clock. Each channel produces a three-state pump command: it sources, it sinks, or it floats. A polarity input per channel picks which of the two trains must lead for the pump to source current.

Each channel also measures every phase error as a count of oscillator clocks. From that count it keeps a lock flag with hysteresis. One large error clears the flag at once. The flag is set again only after a run of small errors. A power-save input per channel stops its comparator and makes it report as locked. The two lock flags are ANDed into one combined flag.

The pump command is split into two bits, an enable and a direction. The enable low means the pump floats. The enable high with the direction high means source. The enable high with the direction low means sink.

Top module: `pfd_dual_lock`

## Requirements
- R1: With `pol_i` high, a reference edge arriving before the feedback edge makes the pump source (`cp_en_o`=1, `cp_hi_o`=1) from the cycle after that edge until the feedback edge arrives. A feedback edge arriving first makes it sink (`cp_en_o`=1, `cp_hi_o`=0).
- R2: With `pol_i` low, the directions of R1 are swapped: a leading reference edge sinks and a leading feedback edge sources.
- R3: When both edges rise in the same clock cycle, the pump stays floating (`cp_en_o`=0). After every completed comparison the pump returns to floating.
- R4: The pump enable stays high for exactly the number of clock cycles between the two rising edges. That count is the phase error of the comparison.
- R5: While locked, the lock flag falls at the clock edge where the running error of the current comparison reaches UNLOCK_CYC (4) cycles. It does not wait for the comparison to finish.
- R6: While unlocked, the flag rises at the end of the LOCK_RUN-th (3rd) consecutive comparison whose error is at most LOCK_CYC (8). A comparison above LOCK_CYC restarts the run. A comparison that caused the unlock never counts toward the run.
- R7: With `pwrsave_i` high, that channel's pump floats in the same cycle and its lock flag reads 1. Edges seen during power save are discarded. After release, the flag stays 1 until a large error occurs.
- R8: `lock_all_o` is 1 exactly when every channel's `lock_o` bit is 1. If all channels are in power save, `lock_all_o` is 1.
- R9: After reset, each pump floats and each lock flag is 0.
- R10: Activity on one channel never changes the pump outputs of the other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fr_i | input | N_CH | Reference pulse train per channel (bit 0 = IF, bit 1 = RF) |
| fp_i | input | N_CH | Divided feedback pulse train per channel |
| pol_i | input | N_CH | Pump polarity per channel |
| pwrsave_i | input | N_CH | Power save per channel, active high |
| cp_en_o | output | N_CH | Pump drive enable; 0 = floating |
| cp_hi_o | output | N_CH | Pump direction when enabled; 1 = source, 0 = sink |
| lock_o | output | N_CH | Per-channel lock flag |
| lock_all_o | output | 1 | AND of all channel lock flags |

## Verification
The comparator is driven with reference-leading, feedback-leading and coincident edge pairs, under both polarities, with offsets from 0 to 9 cycles. These patterns separate direction errors from pulse-width errors and show whether coincident edges produce a spurious pulse. The offset sequence steps across both thresholds. Offsets of 4 to 8 cycles sit in the band where lock is lost but relock runs still count. An offset of 9 restarts a run, and an offset of 6 against a locked channel shows the flag falling mid-comparison. Power save is entered with a comparison half finished, to show that the pending edge is discarded and that the reported lock state is held.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  typedef struct packed {
    logic en;
    logic hi;
  } cp_drv_t;
endpackage

// File: rtl/pfd_detect.sv
module pfd_detect
  import pfd_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fr_i,
  input  logic             fp_i,
  input  logic             pol_i,
  input  logic             pwrsave_i,
  output cp_drv_t          cp_o,
  output logic             evt_o,
  output logic [CNT_W-1:0] err_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic fr_d_q, fp_d_q, up_q, dn_q;
  logic rise_r, rise_p, up_n, dn_n, evt, active;
  logic [CNT_W-1:0] cnt_q, err_now;

  assign rise_r = fr_i & ~fr_d_q;
  assign rise_p = fp_i & ~fp_d_q;
  assign up_n   = up_q | rise_r;
  assign dn_n   = dn_q | rise_p;
  assign evt    = up_n & dn_n;
  assign active = up_q | dn_q;
  // running error including the current cycle, saturating
  assign err_now = (active && cnt_q != CNT_MAX) ? cnt_q + 1'b1 : cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fr_d_q <= 1'b0;
      fp_d_q <= 1'b0;
      up_q   <= 1'b0;
      dn_q   <= 1'b0;
      cnt_q  <= '0;
    end else begin
      fr_d_q <= fr_i;
      fp_d_q <= fp_i;
      if (pwrsave_i) begin
        up_q  <= 1'b0;
        dn_q  <= 1'b0;
        cnt_q <= '0;
      end else begin
        up_q  <= up_n & ~evt;
        dn_q  <= dn_n & ~evt;
        if (evt)         cnt_q <= '0;
        else if (active) cnt_q <= err_now;
      end
    end
  end

  assign cp_o.en = active & ~pwrsave_i;
  assign cp_o.hi = cp_o.en & (pol_i ? up_q : dn_q);
  assign evt_o   = evt & ~pwrsave_i;
  assign err_o   = err_now;

  assert_lead_sets_one_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_r && !rise_p && !active && !pwrsave_i) |=> (up_q && !dn_q));
  assert_coincident_floats_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_r && rise_p && !active && !pwrsave_i) |=> !cp_o.en);
  assert_err_counts_up_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && !evt && !pwrsave_i && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));
  assert_never_both_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(up_q && dn_q));
  assert_pwrsave_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwrsave_i |=> (!up_q && !dn_q && cnt_q == '0));
endmodule

// File: rtl/pfd_lockdet.sv
module pfd_lockdet #(
  parameter int CNT_W      = 8,
  parameter int UNLOCK_CYC = 4,
  parameter int LOCK_CYC   = 8,
  parameter int LOCK_RUN   = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pwrsave_i,
  input  logic             evt_i,
  input  logic [CNT_W-1:0] err_i,
  output logic             lock_o
);
  localparam int RUN_W = $clog2(LOCK_RUN + 1);
  localparam logic [CNT_W-1:0] UNLOCK_TH = CNT_W'(UNLOCK_CYC);
  localparam logic [CNT_W-1:0] LOCK_TH   = CNT_W'(LOCK_CYC);
  localparam logic [RUN_W-1:0] RUN_LAST  = RUN_W'(LOCK_RUN - 1);

  logic lock_q, taint_q, drop;
  logic [RUN_W-1:0] run_q;

  assign drop = lock_q & (err_i >= UNLOCK_TH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q  <= 1'b0;
      taint_q <= 1'b0;
      run_q   <= '0;
    end else if (pwrsave_i) begin
      lock_q  <= 1'b1;
      taint_q <= 1'b0;
      run_q   <= '0;
    end else begin
      if (drop) begin
        lock_q  <= 1'b0;
        taint_q <= 1'b1;
      end
      if (evt_i) begin
        taint_q <= 1'b0;
        if (drop || taint_q) begin
          run_q <= '0;
        end else if (!lock_q) begin
          if (err_i <= LOCK_TH) begin
            if (run_q == RUN_LAST) begin
              lock_q <= 1'b1;
              run_q  <= '0;
            end else begin
              run_q <= run_q + 1'b1;
            end
          end else begin
            run_q <= '0;
          end
        end
      end
    end
  end

  assign lock_o = lock_q | pwrsave_i;

  assert_big_error_unlocks_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && err_i >= UNLOCK_TH && !pwrsave_i) |=> !lock_q);
  assert_relock_on_event_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_q) |-> ($past(evt_i) || $past(pwrsave_i)));
  assert_pwrsave_reports_lock_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwrsave_i |-> lock_o);
endmodule

// File: rtl/pfd_dual_lock.sv
module pfd_dual_lock
  import pfd_pkg::*;
#(
  parameter int N_CH       = 2,
  parameter int CNT_W      = 8,
  parameter int UNLOCK_CYC = 4,
  parameter int LOCK_CYC   = 8,
  parameter int LOCK_RUN   = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] fr_i,
  input  logic [N_CH-1:0] fp_i,
  input  logic [N_CH-1:0] pol_i,
  input  logic [N_CH-1:0] pwrsave_i,
  output logic [N_CH-1:0] cp_en_o,
  output logic [N_CH-1:0] cp_hi_o,
  output logic [N_CH-1:0] lock_o,
  output logic            lock_all_o
);
  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    cp_drv_t          cp;
    logic             evt;
    logic [CNT_W-1:0] err;

    pfd_detect #(.CNT_W(CNT_W)) u_det (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .fr_i      (fr_i[g]),
      .fp_i      (fp_i[g]),
      .pol_i     (pol_i[g]),
      .pwrsave_i (pwrsave_i[g]),
      .cp_o      (cp),
      .evt_o     (evt),
      .err_o     (err)
    );

    pfd_lockdet #(
      .CNT_W(CNT_W), .UNLOCK_CYC(UNLOCK_CYC),
      .LOCK_CYC(LOCK_CYC), .LOCK_RUN(LOCK_RUN)
    ) u_lock (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .pwrsave_i (pwrsave_i[g]),
      .evt_i     (evt),
      .err_i     (err),
      .lock_o    (lock_o[g])
    );

    assign cp_en_o[g] = cp.en;
    assign cp_hi_o[g] = cp.hi;

    assert_pwrsave_floats_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pwrsave_i[g] |-> !cp_en_o[g]);
  end

  assign lock_all_o = &lock_o;

  assert_all_saved_locked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&pwrsave_i) |-> lock_all_o);
endmodule

// File: tb/pfd_dual_lock_tb_top.sv
module pfd_dual_lock_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] fr = '0, fp = '0, pol = '0, ps = '0;
  logic [1:0] cp_en, cp_hi, lock;
  logic       lock_all;

  int checks = 0;
  int fails  = 0;
  logic [1:0] exp_lk = '0;

  always #2 clk = ~clk;

  pfd_dual_lock dut_i (
    .clk_i(clk), .rst_ni(rst_n), .fr_i(fr), .fp_i(fp), .pol_i(pol),
    .pwrsave_i(ps), .cp_en_o(cp_en), .cp_hi_o(cp_hi), .lock_o(lock),
    .lock_all_o(lock_all)
  );

  typedef struct packed {
    logic              ch;
    logic              pol;
    logic signed [7:0] off;
    logic              lk;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1,  8'sd2, 1'b0},
    '{1'b0, 1'b1, -8'sd3, 1'b0},
    '{1'b0, 1'b0,  8'sd1, 1'b1},
    '{1'b0, 1'b0, -8'sd2, 1'b1},
    '{1'b0, 1'b1,  8'sd3, 1'b1},
    '{1'b0, 1'b1,  8'sd6, 1'b0},
    '{1'b0, 1'b1,  8'sd7, 1'b0},
    '{1'b0, 1'b0, -8'sd8, 1'b0},
    '{1'b0, 1'b1,  8'sd9, 1'b0},
    '{1'b0, 1'b1,  8'sd0, 1'b0},
    '{1'b0, 1'b0,  8'sd5, 1'b0},
    '{1'b0, 1'b1, -8'sd4, 1'b1},
    '{1'b1, 1'b1,  8'sd1, 1'b0},
    '{1'b1, 1'b0, -8'sd1, 1'b0},
    '{1'b1, 1'b1,  8'sd0, 1'b1},
    '{1'b1, 1'b1, -8'sd5, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one edge pair; off>0: reference leads by off cycles, off<0: feedback leads
  task automatic run_pair(input int ch, input logic p, input int off,
                          output int bad, output logic lk4, output logic lk5);
    int d = (off < 0) ? -off : off;
    bad = 0;
    lk4 = 1'bx;
    lk5 = 1'bx;
    for (int t = 0; t < d + 3; t++) begin
      @(negedge clk);
      if (t >= 1) begin
        logic ee = (d != 0) && (t <= d);
        logic eh = (off > 0) ? p : ~p;
        if (cp_en[ch] !== ee || (ee && cp_hi[ch] !== eh) || cp_en[1-ch] !== 1'b0) bad++;
        if (t == 4) lk4 = lock[ch];
        if (t == 5) lk5 = lock[ch];
      end
      if (t == 0) pol[ch] = p;
      fr[ch] = (off >= 0) ? (t == 0) : (t == d);
      fp[ch] = (off >= 0) ? (t == d) : (t == 0);
    end
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int   bad;
    logic l4, l5;
    repeat (3) @(negedge clk);
    chk(cp_en === 2'b00, "R9 pump floats after reset", cp_en, 0);
    chk(lock === 2'b00 && lock_all === 1'b0, "R9 lock clear after reset", lock, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(cp_en === 2'b00 && lock === 2'b00, "R9 idle after release", {cp_en, lock}, 0);

    // vector walk: R1 R2 R3 R4 R6 R8 R10
    for (int i = 0; i < NV; i++) begin
      run_pair(int'(VECS[i].ch), VECS[i].pol, int'(VECS[i].off), bad, l4, l5);
      exp_lk[VECS[i].ch] = VECS[i].lk;
      chk(bad == 0, (VECS[i].off == 0) ? "R3 coincident pump" :
          (VECS[i].pol ? "R1 R4 R10 pump pattern" : "R2 R4 R10 pump pattern"), bad, 0);
      chk(lock === exp_lk, "R6 lock flag after comparison", lock, exp_lk);
      chk(lock_all === (&exp_lk), "R8 combined flag", lock_all, &exp_lk);
    end

    // R5: ch0 locked, 6-cycle error drops flag at the 4th cycle
    run_pair(0, 1'b1, 6, bad, l4, l5);
    chk(l4 === 1'b1, "R5 still locked at 3 cycles of error", l4, 1);
    chk(l5 === 1'b0, "R5 unlocked when error reaches 4", l5, 0);
    chk(bad == 0, "R1 R4 pump pattern 6 cycles", bad, 0);
    exp_lk[0] = 1'b0;

    // R7: power save with a pending comparison on ch1 (unlocked)
    @(negedge clk); fr[1] = 1'b1; pol[1] = 1'b1;
    @(negedge clk); fr[1] = 1'b0;
    chk(cp_en[1] === 1'b1, "R1 pump active before power save", cp_en[1], 1);
    ps[1] = 1'b1;
    #1;
    chk(cp_en[1] === 1'b0, "R7 pump floats at once in power save", cp_en[1], 0);
    chk(lock[1] === 1'b1, "R7 power save reports lock", lock[1], 1);
    @(negedge clk); fp[1] = 1'b1;
    @(negedge clk); fp[1] = 1'b0;
    repeat (2) @(negedge clk);
    chk(lock[1] === 1'b1 && cp_en[1] === 1'b0, "R7 held in power save", {lock[1], cp_en[1]}, 2);
    ps[1] = 1'b0;
    repeat (3) @(negedge clk);
    chk(cp_en[1] === 1'b0, "R7 pending edge discarded", cp_en[1], 0);
    chk(lock[1] === 1'b1, "R7 lock kept after release", lock[1], 1);
    exp_lk[1] = 1'b1;
    run_pair(1, 1'b1, 2, bad, l4, l5);
    chk(lock[1] === 1'b1 && bad == 0, "R7 small error keeps lock after release", {lock[1], bad != 0}, 2);

    // R8: one locked, one not, then both
    chk(lock_all === 1'b0, "R8 combined low with ch0 unlocked", lock_all, 0);
    for (int k = 0; k < 3; k++) run_pair(0, 1'b0, 0, bad, l4, l5);
    chk(lock[0] === 1'b1, "R6 relock after three zero errors", lock[0], 1);
    chk(lock_all === 1'b1, "R8 combined high with both locked", lock_all, 1);
    run_pair(0, 1'b1, 9, bad, l4, l5);
    chk(lock_all === 1'b0, "R8 combined low after ch0 loss", lock_all, 0);
    ps = 2'b11;
    #1;
    chk(lock_all === 1'b1, "R8 combined high with both in power save", lock_all, 1);
    @(negedge clk);
    ps = 2'b00;
    @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule